// File: doc/BRIEF.md
# Double-Paired Scanline Pixel Buffer

This block stores one scanline of rendered pixels while the previous scanline is shown. It holds four buffers of 192 entries each, arranged as two pairs, so a pair covers a 384-pixel line. Each entry is a 12-bit palette index: an 8-bit palette bank above a 4-bit color. The renderer writes two pixels per cycle, pixel A and pixel B, one into each buffer of the pair that is in write mode. The display side reads the other pair one pixel at a time, alternating between its two buffers, and presents the palette index on `pix_out`.

Every buffer has its own write enable and its own step input, which advances that buffer's address counter. Each pair has a reload strobe that loads a start address into both of its counters. An order input decides which buffer of a pair takes pixel A and is read first. Entries read for display are cleared to zero, so the pair is empty for its next render pass. A color of zero is transparent and leaves the stored entry as it was. A test port can read or write any entry directly, and it suspends all normal activity while it is in use.

Top module: `scanline_buf`

## Requirements
- R1: While reset is asserted and directly after it, `pix_out` and `tst_rdata` are zero and every buffer entry reads as zero.
- R2: Bit p of `mode` set puts pair p (buffers 2p and 2p+1) in write mode. A buffer of a writing pair with its `wr_we` bit set stores `{bank, color}` at its current address. The first buffer of the pair takes `pix_a` and the second takes `pix_b`.
- R3: A color of zero is not written, and the entry keeps its previous contents.
- R4: A step on a writing buffer advances its address by one after the access. The address wraps from 191 to 0. A reload of a pair sets both of its counters to `start_addr` and takes priority over a step in the same cycle.
- R5: The display pair is pair 1 when `mode[0]` is set, and pair 0 otherwise. It is only active while its own `mode` bit is clear. After a reload, the first buffer of the display pair is current. A step on the current buffer puts its entry on `pix_out` in the next cycle, advances that buffer's address, and makes the other buffer of the pair current. A step on a non-current buffer is ignored.
- R6: An entry read for display is cleared to zero.
- R7: While `tst_en` is high, no normal write, step, reload or display read takes effect. With `tst_we` high, `tst_wdata` is stored at `tst_buf`/`tst_addr`. With `tst_we` low, that entry appears on `tst_rdata` one cycle later and is not cleared.
- R8: With `order` at 0 the even buffer of a pair is first. With `order` at 1 the odd buffer is first. This applies to both the write pixel assignment and the readout order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Per-pair write mode (1) or read mode (0) |
| order | input | 1 | Selects which buffer of a pair is first |
| wr_we | input | 4 | Per-buffer write enable |
| step | input | 4 | Per-buffer address step |
| reload | input | 2 | Per-pair address reload strobe |
| start_addr | input | 8 | Address loaded on reload |
| bank | input | 8 | Palette bank for written pixels |
| pix_a | input | 4 | Color of pixel A |
| pix_b | input | 4 | Color of pixel B |
| tst_en | input | 1 | Test access enable |
| tst_we | input | 1 | Test write (1) or read (0) |
| tst_buf | input | 2 | Test buffer number |
| tst_addr | input | 8 | Test entry address |
| tst_wdata | input | 12 | Test write data |
| pix_out | output | 12 | Display palette index |
| tst_rdata | output | 12 | Test read data |

## Verification
Two functions can land in the same cycle: a test-port access and a display step on the current buffer, and also a reload and a step on the same pair. The bench raises `tst_en` while stepping the current display buffer. It then requires `pix_out` to stay unchanged, and the next normal step must return the entry that was skipped, which shows that neither the address nor the clear-on-read advanced. For the reload case, it pulses reload and step together and confirms through test reads that the next write lands at the start address.

// File: rtl/scanline_buf.sv
module scanline_buf #(
  parameter int DEPTH = 192,
  parameter int BANKW = 8,
  parameter int PIXW  = 4,
  localparam int EW = BANKW + PIXW,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic            order,
  input  logic [3:0]      wr_we,
  input  logic [3:0]      step,
  input  logic [1:0]      reload,
  input  logic [AW-1:0]   start_addr,
  input  logic [BANKW-1:0] bank,
  input  logic [PIXW-1:0] pix_a,
  input  logic [PIXW-1:0] pix_b,
  input  logic            tst_en,
  input  logic            tst_we,
  input  logic [1:0]      tst_buf,
  input  logic [AW-1:0]   tst_addr,
  input  logic [EW-1:0]   tst_wdata,
  output logic [EW-1:0]   pix_out,
  output logic [EW-1:0]   tst_rdata
);

  logic [EW-1:0] mem [4][DEPTH];
  logic [3:0][AW-1:0] addr;
  logic [1:0] phase;
  logic [3:0] rd_hit, wr_hit, adv;
  logic [3:0][PIXW-1:0] wpix;

  wire disp = mode[0];
  wire [1:0] rd_idx = {disp, phase[disp] ^ order};
  wire [AW-1:0] start_ok = (start_addr < AW'(DEPTH)) ? start_addr : '0;

  for (genvar i = 0; i < 4; i++) begin : g_buf
    localparam int P = i / 2;
    localparam logic POS = 1'(i % 2);
    wire first = (POS == order);
    wire is_cur = (POS == (phase[P] ^ order));
    assign wpix[i]   = first ? pix_a : pix_b;
    assign rd_hit[i] = !tst_en && step[i] && !mode[P] && (disp == 1'(P)) && is_cur;
    assign wr_hit[i] = !tst_en && wr_we[i] && mode[P] && (wpix[i] != '0);
    assign adv[i]    = !tst_en && step[i] && (mode[P] || rd_hit[i]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) addr[i] <= '0;
      else if (!tst_en && reload[P]) addr[i] <= start_ok;
      else if (adv[i]) addr[i] <= (addr[i] == AW'(DEPTH-1)) ? '0 : addr[i] + 1'b1;
  end

  for (genvar p = 0; p < 2; p++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) phase[p] <= 1'b0;
      else if (!tst_en && reload[p]) phase[p] <= 1'b0;
      else if (rd_hit[2*p] || rd_hit[2*p+1]) phase[p] <= ~phase[p];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int b = 0; b < 4; b++)
        for (int a = 0; a < DEPTH; a++)
          mem[b][a] <= '0;
    end else if (tst_en) begin
      if (tst_we && tst_addr < AW'(DEPTH)) mem[tst_buf][tst_addr] <= tst_wdata;
    end else begin
      for (int b = 0; b < 4; b++)
        if (rd_hit[b]) mem[b][addr[b]] <= '0;
        else if (wr_hit[b]) mem[b][addr[b]] <= {bank, wpix[b]};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pix_out <= '0;
    else if (|rd_hit) pix_out <= mem[rd_idx][addr[rd_idx]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tst_rdata <= '0;
    else if (tst_en && !tst_we && tst_addr < AW'(DEPTH)) tst_rdata <= mem[tst_buf][tst_addr];

endmodule

module scanline_buf_chk #(
  parameter int DEPTH = 192,
  parameter int EW = 12,
  localparam int AW = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tst_en,
  input logic [3:0]         step,
  input logic [1:0]         reload,
  input logic [AW-1:0]      start_addr,
  input logic [EW-1:0]      pix_out,
  input logic [EW-1:0]      tst_rdata,
  input logic [3:0][AW-1:0] addr
);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (pix_out == '0 && tst_rdata == '0));

  // R7
  tst_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst_en |=> ($stable(pix_out) && $stable(addr)));

  // R4
  reload0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload[0] && !tst_en && start_addr < AW'(DEPTH)) |=> (addr[0] == $past(start_addr) && addr[1] == $past(start_addr)));

  // R4
  reload1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload[1] && !tst_en && start_addr < AW'(DEPTH)) |=> (addr[2] == $past(start_addr) && addr[3] == $past(start_addr)));

  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[0] < AW'(DEPTH) && addr[1] < AW'(DEPTH) && addr[2] < AW'(DEPTH) && addr[3] < AW'(DEPTH)));

  // R5
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pix_out) |-> $past(|step && !tst_en));

endmodule

bind scanline_buf scanline_buf_chk #(.DEPTH(DEPTH), .EW(EW)) u_chk (.*);

// File: tb/scanline_buf_test.sv
module scanline_buf_test;
  localparam int AW = 8;
  localparam int EW = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] mode = 0;
  logic order = 0;
  logic [3:0] wr_we = 0, step = 0;
  logic [1:0] reload = 0;
  logic [AW-1:0] start_addr = 0;
  logic [7:0] bank = 0;
  logic [3:0] pix_a = 0, pix_b = 0;
  logic tst_en = 0, tst_we = 0;
  logic [1:0] tst_buf = 0;
  logic [AW-1:0] tst_addr = 0;
  logic [EW-1:0] tst_wdata = 0;
  logic [EW-1:0] pix_out, tst_rdata;

  int checks = 0, errors = 0;
  logic [EW-1:0] expq[$];
  logic pend = 0;
  string ptag;

  scanline_buf uut (.*);

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [EW-1:0] act, logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (pend && expq.size() > 0) chk(ptag, pix_out, expq.pop_front());
  end

  task automatic reload_pair(int p, logic [AW-1:0] s);
    reload[p] = 1; start_addr = s;
    @(negedge clk);
    reload = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [3:0] b, logic [7:0] bk, logic [3:0] we, logic [3:0] st);
    pix_a = a; pix_b = b; bank = bk; wr_we = we; step = st;
    @(negedge clk);
    wr_we = 0; step = 0;
  endtask

  task automatic disp_step(int b, logic [EW-1:0] exp, string tag);
    step[b] = 1; expq.push_back(exp); ptag = tag; pend = 1;
    @(negedge clk);
    step = 0; pend = 0;
  endtask

  task automatic tread(logic [1:0] b, logic [AW-1:0] a, logic [EW-1:0] exp, string tag);
    tst_en = 1; tst_we = 0; tst_buf = b; tst_addr = a;
    @(negedge clk);
    tst_en = 0;
    chk(tag, tst_rdata, exp);
  endtask

  task automatic twrite(logic [1:0] b, logic [AW-1:0] a, logic [EW-1:0] d);
    tst_en = 1; tst_we = 1; tst_buf = b; tst_addr = a; tst_wdata = d;
    @(negedge clk);
    tst_en = 0; tst_we = 0;
  endtask

  initial begin
    #160000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pix_out", pix_out, '0);
    chk("R1 tst_rdata", tst_rdata, '0);
    tread(0, 0, '0, "R1 entry");
    tread(3, 191, '0, "R1 entry");

    // pair 0 renders, even buffer first
    mode = 2'b01; order = 0;
    reload_pair(0, 0);
    for (int k = 0; k < 6; k++) wr(4'(k + 1), 4'(k + 8), 8'h5A, 4'b0011, 4'b0011);
    reload_pair(0, 3);
    wr(4'd0, 4'd0, 8'hFF, 4'b0011, 4'b0000);
    tread(0, 3, {8'h5A, 4'd4}, "R3 zero A kept");
    wr(4'd7, 4'd0, 8'hFF, 4'b0011, 4'b0000);
    tread(0, 3, {8'hFF, 4'd7}, "R2 write A");
    tread(1, 3, {8'h5A, 4'd11}, "R3 zero B kept");

    // swap: pair 0 displays
    mode = 2'b10;
    reload_pair(0, 0);
    step = 4'b0010;
    @(negedge clk);
    step = 0;
    chk("R5 non-current ignored", pix_out, '0);
    for (int k = 0; k < 6; k++) begin
      disp_step(0, (k == 3) ? {8'hFF, 4'd7} : {8'h5A, 4'(k + 1)}, "R5 readout A");
      disp_step(1, {8'h5A, 4'(k + 8)}, "R5 readout B");
    end
    reload_pair(0, 0);
    disp_step(0, '0, "R6 cleared");
    disp_step(1, '0, "R6 cleared");
    tread(0, 1, '0, "R6 cleared entry");

    // pair 1 renders with odd buffer first, across the wrap
    order = 1;
    reload_pair(1, 190);
    for (int k = 0; k < 3; k++) wr(4'(k + 2), 4'(k + 12), 8'hC3, 4'b1100, 4'b1100);
    mode = 2'b01;
    reload_pair(1, 190);
    for (int k = 0; k < 3; k++) begin
      disp_step(3, {8'hC3, 4'(k + 2)}, "R8 odd first R4 wrap");
      disp_step(2, {8'hC3, 4'(k + 12)}, "R8 second R4 wrap");
    end

    // test port, and collision with a display step
    twrite(2, 5, 12'hABC);
    tread(2, 5, 12'hABC, "R7 test read");
    tread(2, 5, 12'hABC, "R7 no clear");
    reload_pair(1, 5);
    disp_step(3, '0, "R7 setup");
    tst_en = 1; tst_we = 0; tst_buf = 0; tst_addr = 0; step = 4'b0100;
    @(negedge clk);
    tst_en = 0; step = 0;
    chk("R7 step suppressed", pix_out, '0);
    disp_step(2, 12'hABC, "R7 entry kept");

    // reload beats step, pair 0 renders with odd first
    reload[0] = 1; start_addr = 20; step = 4'b0011;
    @(negedge clk);
    reload = 0; step = 0;
    wr(4'd9, 4'd4, 8'h11, 4'b0011, 4'b0000);
    tread(1, 20, {8'h11, 4'd9}, "R4 reload priority");
    tread(0, 20, {8'h11, 4'd4}, "R8 B to even");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule